// File: doc/BRIEF.md
# FOC Control Register Wrapper

This block places a field-oriented current-control datapath behind one memory-mapped slave port. All of the datapath's parallel inputs and outputs are reached only through word registers on that port. Those inputs are the two phase-current samples, the rotor angle, the torque request and the four PI gains. The outputs are the three phase-voltage commands. A bus master loads the inputs and issues a start command. It then waits for completion, either by polling a status bit or by taking an interrupt, and reads back the three voltages. With the four gains left unchanged, one control cycle costs six writes (four inputs, start, status acknowledge) and three reads.

At start, the wrapper freezes every input into a shadow bank that drives the datapath. A host can therefore prepare the next sample while the current one is computing. The three voltage commands are captured together on the edge where the datapath reports completion, so a read never sees a mix of old and new results.

The request channel uses valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops when a read is accepted and stays low until its response has been taken. The response channel also uses valid/ready. `rsp_valid` and `rsp_rdata` hold steady until a rising edge where `rsp_ready` is high. Writes produce no response.

Top module: `foc_mmio_wrap`

## Requirements
- R1: After reset, `busy`, `done`, `irq`, `dp_start` and `rsp_valid` are low, `req_ready` is high, and every register reads as 0.
- R2: The register map uses byte addresses with word index `addr[5:2]`, and all higher address bits must be zero for a hit. The read/write registers are phase current A at 0x08, phase current B at 0x0C, rotor angle at 0x10, torque request at 0x14, and the gains d-Kp at 0x24, d-Ki at 0x28, q-Kp at 0x2C and q-Ki at 0x30. Each keeps the low DW bits of the write data and reads back zero-extended. Unmapped words read 0.
- R3: A read accepted on edge E0 gets a one-cycle wait state. `rsp_valid` rises on edge E0+1 with the data. The response holds its data while `rsp_ready` is low. `req_ready` stays low from E0 until the response has been taken.
- R4: Writing the control word (0x00) with bit 0 set while idle sets `busy` and pulses `dp_start` for exactly one cycle after the write edge. On that same edge, the current input and gain registers are copied to `dp_feedback` and `dp_gains`. In these vectors, lane i is word 0x08+4i or 0x24+4i, and lane 0 sits in the least significant bits.
- R5: While `busy` is high, writes to input or gain registers do not change `dp_feedback` or `dp_gains`, and a further start write is ignored with no `dp_start`. The new values are used at the next start.
- R6: When `dp_done` is high while `busy` is high, the three voltages in `dp_volt` (lanes 0..2) are captured together on one edge into the read-only words 0x18, 0x1C and 0x20. That edge clears `busy` and sets `done`. A `dp_done` while idle is ignored.
- R7: The status word is 0x04, with bit 0 = busy and bit 1 = done. `done` is sticky. It is cleared when a status read returns it, when status is written with bit 1 set, or when a new start is accepted. A completion arriving in the same cycle as a clear takes priority.
- R8: With IRQ_EN set, `irq` rises on the completion edge and stays high until any write to the status word. With IRQ_EN clear, `irq` is held low.
- R9: Writes to the voltage words 0x18, 0x1C and 0x20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Wrapper can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | BUS_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Master takes read data |
| rsp_rdata | output | BUS_W | Read data |
| dp_start | output | 1 | One-cycle compute request to the datapath |
| dp_feedback | output | 4*DW | Frozen currents, angle, torque request |
| dp_gains | output | 4*DW | Frozen PI gains |
| dp_done | input | 1 | Datapath completion pulse |
| dp_volt | input | 3*DW | Datapath voltage results |
| irq | output | 1 | Completion interrupt |

## Verification
On every cycle, the assertions check several invariants. The shadow vectors stay frozen while a computation runs. The voltage words change only on an accepted completion. `busy` and `done` are never high together. Each accepted start yields a single-cycle `dp_start`. The response channel holds under back-pressure. Only the bench's scenarios can show the observable results of these rules: the exact register decoding and masking, the read clear of `done`, the ignored writes to read-only words, the ignored start and ignored completion, and the new values being used at the next start.

// File: rtl/foc_mmio_pkg.sv
package foc_mmio_pkg;
  localparam int WORD_W    = 4;
  localparam int N_FB      = 4;
  localparam int N_OUT     = 3;
  localparam int N_GAIN    = 4;
  localparam int WD_CTRL   = 0;
  localparam int WD_STAT   = 1;
  localparam int FB_BASE   = 2;
  localparam int OUT_BASE  = 6;
  localparam int GAIN_BASE = 9;
  localparam int CTRL_GO   = 0;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;
endpackage

// File: rtl/foc_bus_port.sv
module foc_bus_port #(
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32,
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              wr_fire,
  output logic [WORD_W-1:0] wr_word,
  output logic [BUS_W-1:0]  wr_data,
  output logic              rd_fire,
  output logic [WORD_W-1:0] rd_word,
  input  logic [BUS_W-1:0]  rd_value
);
  localparam int LSB = 2;
  localparam int TOP = WORD_W + LSB;

  logic              hit;
  logic              accept;
  logic              rd_wait;
  logic              rd_hit_q;
  logic [WORD_W-1:0] rd_word_q;

  generate
    if (ADDR_W > TOP) begin : g_wide
      assign hit = ~|req_addr[ADDR_W-1:TOP];
    end else begin : g_narrow
      assign hit = 1'b1;
    end
  endgenerate

  assign req_ready = !rd_wait && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign wr_fire   = accept && req_write && hit;
  assign wr_word   = req_addr[TOP-1:LSB];
  assign wr_data   = req_wdata;
  assign rd_word   = rd_word_q;
  assign rd_fire   = rd_wait && rd_hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_wait   <= 1'b0;
      rd_hit_q  <= 1'b0;
      rd_word_q <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept && !req_write) begin
        rd_wait   <= 1'b1;
        rd_hit_q  <= hit;
        rd_word_q <= req_addr[TOP-1:LSB];
      end else if (rd_wait) begin
        rd_wait <= 1'b0;
      end
      if (rd_wait) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_hit_q ? rd_value : '0;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/foc_reg_bank.sv
module foc_reg_bank #(
  parameter int DW        = 16,
  parameter int BUS_W     = 32,
  parameter int WORD_W    = 4,
  parameter int N_FB      = 4,
  parameter int N_GAIN    = 4,
  parameter int FB_BASE   = 2,
  parameter int GAIN_BASE = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_fire,
  input  logic [WORD_W-1:0]      wr_word,
  input  logic [BUS_W-1:0]       wr_data,
  input  logic                   load,
  output logic [N_FB*DW-1:0]     live_fb,
  output logic [N_FB*DW-1:0]     shadow_fb,
  output logic [N_GAIN*DW-1:0]   live_gain,
  output logic [N_GAIN*DW-1:0]   shadow_gain
);
  genvar i;
  generate
    for (i = 0; i < N_FB; i++) begin : g_fb
      localparam logic [WORD_W-1:0] MYW = WORD_W'(FB_BASE + i);
      logic [DW-1:0] live_q, shad_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_q <= '0;
          shad_q <= '0;
        end else begin
          if (wr_fire && wr_word == MYW) live_q <= wr_data[DW-1:0];
          if (load) shad_q <= live_q;
        end
      end
      assign live_fb[i*DW +: DW]   = live_q;
      assign shadow_fb[i*DW +: DW] = shad_q;
    end
    for (i = 0; i < N_GAIN; i++) begin : g_gain
      localparam logic [WORD_W-1:0] MYW = WORD_W'(GAIN_BASE + i);
      logic [DW-1:0] live_q, shad_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          live_q <= '0;
          shad_q <= '0;
        end else begin
          if (wr_fire && wr_word == MYW) live_q <= wr_data[DW-1:0];
          if (load) shad_q <= live_q;
        end
      end
      assign live_gain[i*DW +: DW]   = live_q;
      assign shadow_gain[i*DW +: DW] = shad_q;
    end
  endgenerate
endmodule

// File: rtl/foc_handshake.sv
module foc_handshake #(
  parameter int DW     = 16,
  parameter int N_OUT  = 3,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go_req,
  input  logic                 stat_wr,
  input  logic                 clr_req,
  input  logic                 rd_clr,
  input  logic                 dp_done,
  input  logic [N_OUT*DW-1:0]  dp_volt,
  output logic                 load,
  output logic                 busy,
  output logic                 done,
  output logic                 dp_start,
  output logic                 irq,
  output logic [N_OUT*DW-1:0]  volt_q
);
  logic finish;
  assign load   = go_req && !busy;
  assign finish = busy && dp_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      dp_start <= 1'b0;
    end else begin
      dp_start <= load;
      if (load) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (clr_req || rd_clr) begin
        done <= 1'b0;
      end
    end
  end

  genvar k;
  generate
    for (k = 0; k < N_OUT; k++) begin : g_out
      always_ff @(posedge clk) begin
        if (!rst_n) volt_q[k*DW +: DW] <= '0;
        else if (finish) volt_q[k*DW +: DW] <= dp_volt[k*DW +: DW];
      end
    end
    if (IRQ_EN) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (finish) irq_q <= 1'b1;
        else if (stat_wr) irq_q <= 1'b0;
      end
      assign irq = irq_q;
    end else begin : g_noirq
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/foc_mmio_wrap.sv
module foc_mmio_wrap
  import foc_mmio_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [BUS_W-1:0]      req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [BUS_W-1:0]      rsp_rdata,
  output logic                  dp_start,
  output logic [N_FB*DW-1:0]    dp_feedback,
  output logic [N_GAIN*DW-1:0]  dp_gains,
  input  logic                  dp_done,
  input  logic [N_OUT*DW-1:0]   dp_volt,
  output logic                  irq
);
  localparam logic [WORD_W-1:0] W_CTRL = WORD_W'(WD_CTRL);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(WD_STAT);

  logic              wr_fire, rd_fire, load;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [BUS_W-1:0]  wr_data, rd_value;
  logic              go_req, stat_wr, clr_req, rd_clr;
  logic              st_busy, st_done;
  logic [N_FB*DW-1:0]   live_fb;
  logic [N_GAIN*DW-1:0] live_gain;
  logic [N_OUT*DW-1:0]  volt_q;

  foc_bus_port #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wr_fire(wr_fire), .wr_word(wr_word), .wr_data(wr_data),
    .rd_fire(rd_fire), .rd_word(rd_word), .rd_value(rd_value)
  );

  assign go_req  = wr_fire && wr_word == W_CTRL && wr_data[CTRL_GO];
  assign stat_wr = wr_fire && wr_word == W_STAT;
  assign clr_req = stat_wr && wr_data[STAT_DONE];
  assign rd_clr  = rd_fire && rd_word == W_STAT;

  foc_reg_bank #(
    .DW(DW), .BUS_W(BUS_W), .WORD_W(WORD_W), .N_FB(N_FB), .N_GAIN(N_GAIN),
    .FB_BASE(FB_BASE), .GAIN_BASE(GAIN_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_word(wr_word),
    .wr_data(wr_data), .load(load),
    .live_fb(live_fb), .shadow_fb(dp_feedback),
    .live_gain(live_gain), .shadow_gain(dp_gains)
  );

  foc_handshake #(.DW(DW), .N_OUT(N_OUT), .IRQ_EN(IRQ_EN)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .stat_wr(stat_wr),
    .clr_req(clr_req), .rd_clr(rd_clr), .dp_done(dp_done), .dp_volt(dp_volt),
    .load(load), .busy(st_busy), .done(st_done), .dp_start(dp_start),
    .irq(irq), .volt_q(volt_q)
  );

  always_comb begin
    rd_value = '0;
    if (rd_word == W_STAT) begin
      rd_value[STAT_BUSY] = st_busy;
      rd_value[STAT_DONE] = st_done;
    end
    for (int i = 0; i < N_FB; i++)
      if (rd_word == WORD_W'(FB_BASE + i)) rd_value[DW-1:0] = live_fb[i*DW +: DW];
    for (int i = 0; i < N_OUT; i++)
      if (rd_word == WORD_W'(OUT_BASE + i)) rd_value[DW-1:0] = volt_q[i*DW +: DW];
    for (int i = 0; i < N_GAIN; i++)
      if (rd_word == WORD_W'(GAIN_BASE + i)) rd_value[DW-1:0] = live_gain[i*DW +: DW];
  end
endmodule

// File: rtl/foc_mmio_wrap_chk.sv
module foc_mmio_wrap_chk #(
  parameter int DW     = 16,
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BUS_W-1:0]  req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BUS_W-1:0]  rsp_rdata,
  input logic              dp_start,
  input logic              dp_done,
  input logic [4*DW-1:0]   dp_feedback,
  input logic [4*DW-1:0]   dp_gains,
  input logic [3*DW-1:0]   volt_q,
  input logic              busy,
  input logic              done,
  input logic              irq
);
  logic go_seen;
  assign go_seen = req_valid && req_ready && req_write &&
                   req_addr[ADDR_W-1:2] == '0 && req_wdata[0] && !busy;

  a_r4_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    go_seen |=> busy && dp_start);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> !dp_start);

  a_r5_inputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(dp_feedback) && $stable(dp_gains));

  a_r6_volt_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(volt_q) |-> $past(dp_done && busy));

  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done);
endmodule

bind foc_mmio_wrap foc_mmio_wrap_chk #(.DW(DW), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .dp_start(dp_start), .dp_done(dp_done), .dp_feedback(dp_feedback),
  .dp_gains(dp_gains), .volt_q(volt_q), .busy(st_busy), .done(st_done),
  .irq(irq)
);

// File: tb/foc_mmio_wrap_bench.sv
`timescale 1ns/1ps
module foc_mmio_wrap_bench;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int BW = 32;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [BW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, dp_start, irq;
  logic [BW-1:0] rsp_rdata;
  logic [4*DW-1:0] dp_feedback, dp_gains;
  logic          dp_done = 1'b0;
  logic [3*DW-1:0] dp_volt = '0;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  foc_mmio_wrap #(.DW(DW), .ADDR_W(AW), .BUS_W(BW), .IRQ_EN(1'b1)) u_foc_mmio_wrap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dp_start(dp_start), .dp_feedback(dp_feedback), .dp_gains(dp_gains),
    .dp_done(dp_done), .dp_volt(dp_volt), .irq(irq)
  );

  // {address, write data, expected read-back}
  localparam logic [69:0] VEC [NV] = '{
    {6'h08, 32'h1234ABCD, 32'h0000ABCD},
    {6'h0C, 32'h00008001, 32'h00008001},
    {6'h10, 32'hFFFFFFFF, 32'h0000FFFF},
    {6'h14, 32'h00000042, 32'h00000042},
    {6'h24, 32'h00000011, 32'h00000011},
    {6'h28, 32'h00000022, 32'h00000022},
    {6'h2C, 32'h00000033, 32'h00000033},
    {6'h30, 32'h00000044, 32'h00000044},
    {6'h18, 32'h00005555, 32'h00000000},
    {6'h20, 32'h00007777, 32'h00000000},
    {6'h34, 32'h00009999, 32'h00000000},
    {6'h3C, 32'h0000AAAA, 32'h00000000}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [BW-1:0] d, input int hold);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 wait state", {62'd0, rsp_valid, req_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 response valid", {63'd0, rsp_valid}, 64'd1);
    d = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R3 hold under back-pressure", {30'd0, rsp_valid, req_ready, rsp_rdata}, {30'd0, 1'b1, 1'b0, d});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R3 response taken", {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  task automatic finish_dp(input logic [3*DW-1:0] v);
    @(negedge clk);
    dp_volt = v; dp_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dp_done = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [BW-1:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {59'd0, req_ready, rsp_valid, dp_start, irq, 1'b0}, {59'd0, 5'b10000});
    rd(6'h04, got, 0); chk("R1 status after reset", got, 0);
    rd(6'h08, got, 0); chk("R1 current A after reset", got, 0);
    rd(6'h24, got, 0); chk("R1 gain after reset", got, 0);
    rd(6'h18, got, 0); chk("R1 voltage after reset", got, 0);

    // R2 / R9 register table
    for (int k = 0; k < NV; k++) begin
      wr(VEC[k][69:64], VEC[k][63:32]);
      rd(VEC[k][69:64], got, 0);
      if (VEC[k][69:64] == 6'h18 || VEC[k][69:64] == 6'h20)
        chk("R9 read-only voltage word", got, VEC[k][31:0]);
      else
        chk("R2 register read-back", got, VEC[k][31:0]);
    end

    // R3 back-pressure
    rd(6'h0C, got, 3); chk("R3 held data", got, 32'h8001);

    // R4 start
    wr(6'h00, 32'h1);
    chk("R4 start pulse", {63'd0, dp_start}, 64'd1);
    chk("R4 feedback frozen", dp_feedback, 64'h0042_FFFF_8001_ABCD);
    chk("R4 gains frozen", dp_gains, 64'h0044_0033_0022_0011);
    @(negedge clk);
    chk("R4 pulse one cycle", {63'd0, dp_start}, 64'd0);
    rd(6'h04, got, 0); chk("R4 busy in status", got, 32'h1);

    // R5 writes while busy
    wr(6'h08, 32'h1111);
    wr(6'h28, 32'h0999);
    chk("R5 feedback unchanged", dp_feedback, 64'h0042_FFFF_8001_ABCD);
    chk("R5 gains unchanged", dp_gains, 64'h0044_0033_0022_0011);
    wr(6'h00, 32'h1);
    chk("R5 start ignored while busy", {63'd0, dp_start}, 64'd0);
    rd(6'h08, got, 0); chk("R5 live register written", got, 32'h1111);

    // R6 completion
    finish_dp(48'h0333_0222_0111);
    chk("R8 irq on completion", {63'd0, irq}, 64'd1);
    rd(6'h18, got, 0); chk("R6 voltage 0", got, 32'h0111);
    rd(6'h1C, got, 0); chk("R6 voltage 1", got, 32'h0222);
    rd(6'h20, got, 0); chk("R6 voltage 2", got, 32'h0333);
    rd(6'h04, got, 0); chk("R7 done visible", got, 32'h2);
    rd(6'h04, got, 0); chk("R7 done cleared by read", got, 32'h0);
    chk("R8 irq held until status write", {63'd0, irq}, 64'd1);
    wr(6'h04, 32'h0);
    chk("R8 irq cleared by status write", {63'd0, irq}, 64'd0);

    // R6 done while idle ignored
    finish_dp(48'h0AAA_0BBB_0CCC);
    rd(6'h18, got, 0); chk("R6 idle done ignored", got, 32'h0111);
    rd(6'h04, got, 0); chk("R6 idle done no status", got, 32'h0);
    chk("R8 no irq on idle done", {63'd0, irq}, 64'd0);

    // R5 next start uses new values
    wr(6'h00, 32'h1);
    chk("R5 new values at next start", dp_feedback[15:0], 16'h1111);
    chk("R5 new gain at next start", dp_gains[31:16], 16'h0999);
    finish_dp(48'h0003_0002_0001);
    rd(6'h1C, got, 0); chk("R6 second result", got, 32'h0002);

    // R7 clear by status write bit1
    wr(6'h04, 32'h2);
    rd(6'h04, got, 0); chk("R7 done cleared by write", got, 32'h0);

    // R7 new start clears done
    wr(6'h00, 32'h1);
    finish_dp(48'h0006_0005_0004);
    wr(6'h00, 32'h1);
    rd(6'h04, got, 0); chk("R7 start clears done", got, 32'h1);
    finish_dp(48'h0009_0008_0007);
    rd(6'h20, got, 0); chk("R6 third result", got, 32'h0009);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule